// File: doc/BRIEF.md
# Shared interrupt router

This block collects a parameterized set of external interrupt inputs and distributes them to several processor cores. Each input is brought into the clock domain through a two-stage synchronizer. Each input can be qualified in one of four ways: as a level, as a rising or falling edge, or on both edges. Every source has its own enable bit and steers to exactly one destination core. Each core gets one request line, the OR of all pending, enabled sources steered to it.

Software reaches the block through a flat 32-bit register port addressed by word. The write strobe commits on the clock edge, and read data is combinational from the address. Enable bits are changed through separate write-one-to-set and write-one-to-clear registers. Edge-latched pending flags are raised or dropped through a single indexed injection register. The same register serves for software-generated interrupts and for acknowledging edge interrupts.

Address map, as 9-bit word addresses (b = 32-source bank index, up to 15):

- 0x000 identity.
- 0x010+b inversion (1 = active-low / falling edge).
- 0x020+b mode (1 = edge, 0 = level).
- 0x030+b both-edges.
- 0x040+b enable (read).
- 0x050+b enable-set.
- 0x060+b enable-clear.
- 0x070+b pending (read).
- 0x080 injection.
- 0x100+n destination of source n.

Reads of other addresses, and bits above the last source, return 0.

Top module: `shirq_router`

## Requirements
- R1: After reset, inversion, mode, both-edges and enable bits are all 0, every destination reads 0, and no core request is asserted.
- R2: The identity word at 0x000 returns NUM_SRC/8-1 in bits [7:0] and NUM_CORES-1 in bits [15:8], with 0 elsewhere.
- R3: A source in level mode reads pending while its synchronized input XOR its inversion bit is 1, two clocks after the input changes. No acknowledge is needed, and the enable bit has no effect on the pending value.
- R4: A source in edge mode with both-edges off latches pending three clocks after a rising input edge (inversion 0) or a falling input edge (inversion 1). The opposite transition leaves the flag unchanged.
- R5: With both-edges set, a source in edge mode latches pending on either transition, and its inversion bit is ignored.
- R6: Writing 1s to enable-set turns those enables on, and writing 1s to enable-clear turns them off. Zero bits change nothing, and the enable register reads back the result. Bits above the last source read 0.
- R7: An injection write carries the source number in bits [15:0] and the action in bit 31 (1 = set, 0 = clear). It sets or clears that source's edge-latched flag on the next clock. A number at or above NUM_SRC has no effect.
- R8: When a hardware edge event and an injection clear hit the same source in the same cycle, the flag ends set.
- R9: Writing a core number below NUM_CORES to a source's destination register replaces its routing. A value at or above NUM_CORES leaves the routing unchanged.
- R10: Request line c is high exactly when some source is pending, enabled and steered to core c, in the same cycle as that state.
- R11: An edge-latched pending flag stays set after the input returns to its idle level, until an injection clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, committed on the rising clock edge |
| reg_addr | input | 9 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_in | input | NUM_SRC | Raw external interrupt inputs |
| core_irq | output | NUM_CORES | One request line per core |

## Verification
The bench builds the router with NUM_SRC = 40 and NUM_CORES = 3. Forty sources span a full bank and a partly filled second bank, so bank selection, zero padding above the last source and out-of-range injection numbers all come within reach. Three cores leave one destination code (3) unused, which exercises rejection of an invalid routing write. Random traffic mixes input toggles with writes to every register class, so edge events coincide with injection clears and reroutes.

// File: rtl/shirq_router.sv
module shirq_router #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [8:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic [NUM_CORES-1:0] core_irq
);
  localparam int NBANK = (NUM_SRC + 31) / 32;
  localparam int PW    = NBANK * 32;
  localparam int CW    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [31:0] IDENT = {16'h0, 8'(NUM_CORES - 1), 8'(NUM_SRC / 8 - 1)};

  logic [NUM_SRC-1:0] sync1, sync2, prev;
  logic [NUM_SRC-1:0] inv_q, edge_q, both_q, en_q, latch_q;
  logic [CW-1:0]      dest_q [NUM_SRC];

  logic [PW-1:0]      wsel_p, wvec_p;
  logic [NUM_SRC-1:0] wsel, wbits, edge_ev, pend, inj_hit;

  wire in_bank  = reg_we && !reg_addr[8];
  wire wr_inv   = in_bank && reg_addr[7:4] == 4'h1;
  wire wr_mode  = in_bank && reg_addr[7:4] == 4'h2;
  wire wr_both  = in_bank && reg_addr[7:4] == 4'h3;
  wire wr_enset = in_bank && reg_addr[7:4] == 4'h5;
  wire wr_enclr = in_bank && reg_addr[7:4] == 4'h6;
  wire wr_inj   = reg_we && reg_addr == 9'h080;
  wire wr_dest  = reg_we && reg_addr[8];

  always_comb begin
    wsel_p = '0;
    wvec_p = '0;
    for (int k = 0; k < NBANK; k++)
      if (reg_addr[3:0] == 4'(k)) begin
        wsel_p[k*32 +: 32] = '1;
        wvec_p[k*32 +: 32] = reg_wdata;
      end
  end
  assign wsel  = wsel_p[NUM_SRC-1:0];
  assign wbits = wvec_p[NUM_SRC-1:0] & wsel;

  always_comb
    for (int i = 0; i < NUM_SRC; i++)
      inj_hit[i] = wr_inj && reg_wdata[15:0] == 16'(i);

  assign edge_ev = edge_q & ((both_q & (sync2 ^ prev)) |
                             (~both_q & ~inv_q & sync2 & ~prev) |
                             (~both_q & inv_q & ~sync2 & prev));

  assign pend = (edge_q & latch_q) | (~edge_q & (sync2 ^ inv_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      inv_q   <= '0;
      edge_q  <= '0;
      both_q  <= '0;
      en_q    <= '0;
      latch_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) dest_q[i] <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (wr_inv)   inv_q  <= (inv_q  & ~wsel) | wbits;
      if (wr_mode)  edge_q <= (edge_q & ~wsel) | wbits;
      if (wr_both)  both_q <= (both_q & ~wsel) | wbits;
      if (wr_enset) en_q   <= en_q | wbits;
      if (wr_enclr) en_q   <= en_q & ~wbits;
      latch_q <= edge_ev
               | (inj_hit & {NUM_SRC{reg_wdata[31]}})
               | (latch_q & ~(inj_hit & {NUM_SRC{~reg_wdata[31]}}));
      for (int i = 0; i < NUM_SRC; i++)
        if (wr_dest && reg_addr[7:0] == 8'(i) && reg_wdata < 32'(NUM_CORES))
          dest_q[i] <= reg_wdata[CW-1:0];
    end
  end

  function automatic logic [31:0] pick(input logic [NUM_SRC-1:0] v, input logic [3:0] b);
    logic [PW-1:0] p;
    p = PW'(v);
    pick = '0;
    for (int k = 0; k < NBANK; k++)
      if (b == 4'(k)) pick = p[k*32 +: 32];
  endfunction

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[8]) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (reg_addr[7:0] == 8'(i)) reg_rdata[CW-1:0] = dest_q[i];
    end else begin
      case (reg_addr[7:4])
        4'h0: if (reg_addr[3:0] == 4'h0) reg_rdata = IDENT;
        4'h1: reg_rdata = pick(inv_q,  reg_addr[3:0]);
        4'h2: reg_rdata = pick(edge_q, reg_addr[3:0]);
        4'h3: reg_rdata = pick(both_q, reg_addr[3:0]);
        4'h4: reg_rdata = pick(en_q,   reg_addr[3:0]);
        4'h7: reg_rdata = pick(pend,   reg_addr[3:0]);
        default: reg_rdata = '0;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_SRC-1:0] mine;
    always_comb
      for (int i = 0; i < NUM_SRC; i++)
        mine[i] = dest_q[i] == CW'(c);
    assign core_irq[c] = |(pend & en_q & mine);
  end
endmodule

// File: rtl/shirq_router_chk.sv
module shirq_router_chk #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CORES = 4,
  parameter int CW        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [8:0]           reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [NUM_SRC-1:0]   en,
  input logic [NUM_SRC-1:0]   latch,
  input logic [NUM_SRC-1:0]   ev,
  input logic [NUM_SRC-1:0]   pend,
  input logic [CW-1:0]        dest0,
  input logic [NUM_CORES-1:0] core_irq
);
  wire inj0 = reg_we && reg_addr == 9'h080 && reg_wdata[15:0] == 16'h0;

  AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 9'h050 && reg_wdata[0]) |=> en[0]); // R6
  AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 9'h060 && reg_wdata[0]) |=> !en[0]); // R6
  AST_INJECT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (inj0 && reg_wdata[31]) |=> latch[0]); // R7
  AST_INJECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (inj0 && !reg_wdata[31] && !ev[0]) |=> !latch[0]); // R7
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (inj0 && !reg_wdata[31] && ev[0]) |=> latch[0]); // R8
  AST_DEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 9'h100 && reg_wdata >= 32'(NUM_CORES)) |=> $stable(dest0)); // R9
  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq != '0) |-> (|(pend & en))); // R10
endmodule

bind shirq_router shirq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .en(en_q), .latch(latch_q), .ev(edge_ev), .pend(pend), .dest0(dest_q[0]),
  .core_irq(core_irq));

// File: tb/shirq_router_test.sv
module shirq_router_test;
  localparam int NS = 40;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NS-1:0] irq_in = '0;
  wire [31:0] rdata;
  wire [NC-1:0] core_irq;

  always #4 clk = ~clk;

  shirq_router #(.NUM_SRC(NS), .NUM_CORES(NC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_in(irq_in), .core_irq(core_irq));

  logic [NS-1:0] m_inv = '0, m_mode = '0, m_both = '0, m_en = '0, m_lat = '0;
  logic [NS-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
  int m_dest[NS];
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  function automatic logic [NS-1:0] m_pend();
    return (m_mode & m_lat) | (~m_mode & (m_s2 ^ m_inv));
  endfunction

  function automatic logic [NC-1:0] m_core();
    logic [NC-1:0] r = '0;
    logic [NS-1:0] p = m_pend() & m_en;
    for (int i = 0; i < NS; i++) if (p[i]) r[m_dest[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] bank(logic [NS-1:0] v, int b);
    logic [63:0] p = 64'(v);
    if (b > 1) return '0;
    return p[b*32 +: 32];
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    int b = a[3:0];
    if (a[8]) return (a[7:0] < NS) ? 32'(m_dest[a[7:0]]) : 32'h0;
    case (a[7:4])
      4'h0: return (a[3:0] == 0) ? 32'h0000_0204 : 32'h0;
      4'h1: return bank(m_inv, b);
      4'h2: return bank(m_mode, b);
      4'h3: return bank(m_both, b);
      4'h4: return bank(m_en, b);
      4'h7: return bank(m_pend(), b);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [8:0] a);
    if (a[8]) return "R9";
    case (a[7:4])
      4'h0: return "R2";
      4'h4: return "R6";
      4'h7: return "R3/R4/R5/R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h (addr=%h)", req, act, exp, addr);
    end
  endtask

  task automatic model_edge();
    logic [NS-1:0] ev;
    logic [NS-1:0] sel = '0;
    ev = m_mode & ((m_both & (m_s2 ^ m_s3)) | (~m_both & ~m_inv & m_s2 & ~m_s3) |
                   (~m_both & m_inv & ~m_s2 & m_s3));
    if (we && !addr[8] && addr[3:0] < 2)
      for (int i = 0; i < NS; i++) if (i / 32 == addr[3:0]) sel[i] = wdata[i % 32];
    if (we && !addr[8]) begin
      for (int i = 0; i < NS; i++) begin
        if (i / 32 != addr[3:0]) continue;
        case (addr[7:4])
          4'h1: m_inv[i]  = sel[i];
          4'h2: m_mode[i] = sel[i];
          4'h3: m_both[i] = sel[i];
          4'h5: if (sel[i]) m_en[i] = 1'b1;
          4'h6: if (sel[i]) m_en[i] = 1'b0;
          default: ;
        endcase
      end
    end
    if (we && addr == 9'h080 && wdata[15:0] < NS) begin
      if (wdata[31]) m_lat[wdata[15:0]] = 1'b1;
      else m_lat[wdata[15:0]] = 1'b0;
    end
    m_lat = m_lat | ev;
    if (we && addr[8] && addr[7:0] < NS && wdata < NC) m_dest[addr[7:0]] = int'(wdata);
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = irq_in;
  endtask

  task automatic step();
    #1;
    chk("R10", 32'(core_irq), 32'(m_core()));
    if (!we) chk(rtag(addr), rdata, m_read(addr));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, string req, logic [31:0] exp);
    we = 1'b0; addr = a;
    #1;
    chk(req, rdata, exp);
    #0 step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      we = 1'b0; addr = 9'h070;
      step();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) m_dest[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", 32'(core_irq), 32'h0);
    for (int b = 0; b < 2; b++) begin
      rd(9'h010 + 9'(b), "R1", 32'h0);
      rd(9'h020 + 9'(b), "R1", 32'h0);
      rd(9'h030 + 9'(b), "R1", 32'h0);
      rd(9'h040 + 9'(b), "R1", 32'h0);
    end
    rd(9'h105, "R1", 32'h0);
    // R2 identity
    rd(9'h000, "R2", 32'h0000_0204);

    // R6 enable set/clear
    wr(9'h050, 32'hF0F0_00FF);
    rd(9'h040, "R6", 32'hF0F0_00FF);
    wr(9'h060, 32'h0000_000F);
    rd(9'h040, "R6", 32'hF0F0_00F0);
    wr(9'h050, 32'h0);
    wr(9'h060, 32'h0);
    rd(9'h040, "R6", 32'hF0F0_00F0);
    wr(9'h051, 32'hFFFF_FFFF);
    rd(9'h041, "R6", 32'h0000_00FF);

    // R3 level source 1, enable off
    irq_in[1] = 1'b1;
    idle(1);
    rd(9'h070, "R3", 32'h0);
    rd(9'h070, "R3", 32'h2);
    chk("R3", 32'(core_irq), 32'h0);
    wr(9'h050, 32'h2);
    #1 chk("R10", 32'(core_irq), 32'h1);
    wr(9'h010, 32'h2);
    rd(9'h070, "R3", 32'h0);
    wr(9'h010, 32'h0);

    // R9 routing
    wr(9'h101, 32'h2);
    #1 chk("R9", 32'(core_irq), 32'h4);
    wr(9'h101, 32'h3);
    rd(9'h101, "R9", 32'h2);
    irq_in[1] = 1'b0;
    idle(3);

    // R4 rising edge source 4
    wr(9'h020, 32'h10);
    irq_in[4] = 1'b1;
    idle(2);
    rd(9'h070, "R4", 32'h0);
    rd(9'h070, "R4", 32'h10);
    irq_in[4] = 1'b0;
    idle(4);
    rd(9'h070, "R11", 32'h10);
    wr(9'h080, 32'h0000_0004);
    rd(9'h070, "R7", 32'h0);
    idle(3);
    rd(9'h070, "R4", 32'h0);

    // R5 both edges, inversion ignored
    wr(9'h030, 32'h10);
    wr(9'h010, 32'h10);
    irq_in[4] = 1'b1;
    idle(3);
    rd(9'h070, "R5", 32'h10);
    wr(9'h080, 32'h0000_0004);
    irq_in[4] = 1'b0;
    idle(3);
    rd(9'h070, "R5", 32'h10);
    wr(9'h080, 32'h0000_0004);
    rd(9'h070, "R5", 32'h0);

    // R8 edge and clear in the same cycle
    irq_in[4] = 1'b1;
    idle(2);
    wr(9'h080, 32'h0000_0004);
    rd(9'h070, "R8", 32'h10);
    wr(9'h080, 32'h0000_0004);

    // R7 injection: bank 1, out of range
    wr(9'h021, 32'h2);
    wr(9'h080, 32'h8000_0021);
    rd(9'h071, "R7", 32'h2);
    wr(9'h080, 32'h8000_0028);
    rd(9'h071, "R7", 32'h2);
    wr(9'h080, 32'h0000_0021);
    rd(9'h071, "R7", 32'h0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 == 0) irq_in[$urandom % NS] = ~irq_in[$urandom % NS];
      if ($urandom % 2 == 0) begin
        int r = $urandom % 9;
        we = 1'b0;
        case (r)
          0: addr = 9'h000;
          1, 2, 3, 4, 5: addr = {1'b0, 4'(r), 4'($urandom % 3)};
          6, 7: addr = {1'b0, 4'h7, 4'($urandom % 2)};
          default: addr = 9'h100 + 9'($urandom % 44);
        endcase
        step();
      end else begin
        int r = $urandom % 8;
        logic [31:0] d = $urandom;
        case (r)
          0: wr({1'b0, 4'h1, 4'($urandom % 2)}, d);
          1: wr({1'b0, 4'h2, 4'($urandom % 2)}, d);
          2: wr({1'b0, 4'h3, 4'($urandom % 2)}, d);
          3: wr({1'b0, 4'h5, 4'($urandom % 2)}, d);
          4: wr({1'b0, 4'h6, 4'($urandom % 2)}, d & $urandom);
          5, 6: wr(9'h080, {d[31], 15'h0, 16'($urandom % 44)});
          default: wr(9'h100 + 9'($urandom % NS), 32'($urandom % 4));
        endcase
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule